// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block holds one atomic reservation for each hardware thread of a small multithreaded core. A load-linked request from a thread records the 16-byte granule its address falls in and marks that thread's reservation as live. A later store-conditional from the same thread is judged against that record. The block answers whether the store may proceed to memory and returns a result code together with the reason for any failure.

Uncacheable store-conditionals skip the judgement: they always proceed and get their own result code. A separate invalidate input models writes by other agents: any live reservation on the written granule is dropped. To help find livelock, the block counts store-conditional failures in a row. It pulses a warning on every tenth failure and raises a sticky fatal flag when the run reaches a hard limit.

Top module: `llsc_monitor`

## Requirements
- R1: `req_ready` is 0 during reset and 1 otherwise. A request is accepted when `req_valid` and `req_ready` are both 1. Each accepted store-conditional (`req_op`=1) gives exactly one `rsp_valid` pulse in the following cycle, carrying its thread ID in `rsp_tid`. Load-linked (`req_op`=0) and idle cycles give `rsp_valid`=0, and in those cycles every response field is 0.
- R2: An accepted load-linked request stores `req_addr` with bits [3:0] ignored and makes that thread's reservation live. A store-conditional anywhere in the same 16-byte granule then succeeds.
- R3: A cacheable store-conditional (`req_uncached`=0) whose thread has no live reservation fails. It returns `rsp_code`=0 and `rsp_fwd`=0, with `rsp_cause`=1 (no reservation). This cause wins even when the addresses also differ.
- R4: A cacheable store-conditional whose thread has a live reservation on a different granule fails. It returns `rsp_code`=0, `rsp_fwd`=0 and `rsp_cause`=2 (granule mismatch), and the reservation is dropped.
- R5: A cacheable store-conditional that matches a live reservation returns `rsp_code`=1, `rsp_fwd`=1 and `rsp_cause`=0. Every cacheable store-conditional, whether it passes or fails, leaves its thread's reservation dropped.
- R6: An uncacheable store-conditional returns `rsp_code`=2, `rsp_fwd`=1 and `rsp_cause`=0. It leaves every reservation and the failure count unchanged.
- R7: Reservations are independent per thread. A request from one thread never changes another thread's reservation.
- R8: When `inv_valid`=1, every live reservation whose granule equals that of `inv_addr` is dropped, whether or not a request is present. If a load-linked request is accepted in the same cycle, that request's new reservation takes effect.
- R9: Every failed store-conditional adds one to a consecutive-failure count. When the new count is a multiple of 10, `warn_pulse` is 1 in the same cycle as that failure's response, and it is 0 in all other cycles.
- R10: A successful store-conditional clears the failure count and so does reset. An uncacheable one leaves the count unchanged.
- R11: When the failure count reaches 5000, `livelock` rises in the response cycle of that failure and stays 1 until reset. The count saturates at 5000, and failures after that give no warning pulse.
- R12: After reset no reservation is live, and `rsp_valid`, `warn_pulse` and `livelock` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 1 | 0 = load-linked, 1 = store-conditional |
| req_tid | input | TID_W (2) | Issuing thread |
| req_addr | input | ADDR_W (32) | Physical address |
| req_uncached | input | 1 | Store-conditional targets uncacheable space |
| inv_valid | input | 1 | Remote write seen |
| inv_addr | input | ADDR_W (32) | Address of the remote write |
| rsp_valid | output | 1 | Store-conditional result present |
| rsp_tid | output | TID_W (2) | Thread of the result |
| rsp_code | output | 2 | 0 fail, 1 success, 2 uncached pass-through |
| rsp_cause | output | 2 | 0 none, 1 no reservation, 2 granule mismatch |
| rsp_fwd | output | 1 | Store may be sent to memory |
| warn_pulse | output | 1 | Failure count hit a multiple of 10 |
| livelock | output | 1 | Sticky: failure count reached the limit |

## Verification
A lost or stale reservation bit is not visible on its own. It shows up at the next store-conditional from that thread, as a wrong `rsp_code` and `rsp_cause` one cycle after that request is accepted. The reference model is compared on every clock, so such an error is caught in the first response that depends on it. A failure counter that has drifted shows up as a misplaced `warn_pulse` within ten failures, or as a `livelock` edge at the wrong cycle.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic {
        OP_LOAD_LINK  = 1'b0,
        OP_STORE_COND = 1'b1
    } llsc_op_e;

    typedef enum logic [1:0] {
        SC_FAIL   = 2'd0,
        SC_PASS   = 2'd1,
        SC_BYPASS = 2'd2
    } sc_code_e;

    typedef enum logic [1:0] {
        WHY_NONE    = 2'd0,
        WHY_NO_RESV = 2'd1,
        WHY_GRANULE = 2'd2
    } sc_why_e;

    typedef struct packed {
        sc_code_e code;
        sc_why_e  why;
        logic     fwd;
        logic     failed;
        logic     passed;
    } sc_verdict_t;

endpackage

// File: rtl/llsc_resv_bank.sv
module llsc_resv_bank #(
    parameter int NTHREADS = 4,
    parameter int TAG_W    = 28,
    localparam int TID_W   = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             set_en,
    input  logic [TID_W-1:0]                 set_tid,
    input  logic [TAG_W-1:0]                 set_tag,
    input  logic                             drop_en,
    input  logic [TID_W-1:0]                 drop_tid,
    input  logic                             snoop_en,
    input  logic [TAG_W-1:0]                 snoop_tag,
    output logic [NTHREADS-1:0]              live_o,
    output logic [NTHREADS-1:0][TAG_W-1:0]   tag_o
);

    for (genvar t = 0; t < NTHREADS; t++) begin : g_thread
        logic             live_q;
        logic [TAG_W-1:0] tag_q;
        logic             hit_set;
        logic             hit_drop;
        logic             hit_snoop;

        assign hit_set   = set_en && (set_tid == TID_W'(t));
        assign hit_drop  = drop_en && (drop_tid == TID_W'(t));
        assign hit_snoop = snoop_en && live_q && (tag_q == snoop_tag);

        always_ff @(posedge clk) begin
            if (rst) begin
                live_q <= 1'b0;
                tag_q  <= '0;
            end else if (hit_set) begin
                live_q <= 1'b1;
                tag_q  <= set_tag;
            end else if (hit_drop || hit_snoop) begin
                live_q <= 1'b0;
            end
        end

        assign live_o[t] = live_q;
        assign tag_o[t]  = tag_q;
    end

endmodule

// File: rtl/llsc_sc_judge.sv
module llsc_sc_judge
    import llsc_pkg::*;
#(
    parameter int TAG_W = 28
) (
    input  logic             uncached,
    input  logic             live,
    input  logic [TAG_W-1:0] held_tag,
    input  logic [TAG_W-1:0] req_tag,
    output sc_verdict_t      verdict
);

    always_comb begin
        verdict = '{code: SC_PASS, why: WHY_NONE, fwd: 1'b1, failed: 1'b0, passed: 1'b1};
        if (uncached) begin
            verdict.code   = SC_BYPASS;
            verdict.passed = 1'b0;
        end else if (!live) begin
            verdict = '{code: SC_FAIL, why: WHY_NO_RESV, fwd: 1'b0, failed: 1'b1, passed: 1'b0};
        end else if (held_tag != req_tag) begin
            verdict = '{code: SC_FAIL, why: WHY_GRANULE, fwd: 1'b0, failed: 1'b1, passed: 1'b0};
        end
    end

endmodule

// File: rtl/llsc_fail_tracker.sv
module llsc_fail_tracker #(
    parameter int WARN_EVERY = 10,
    parameter int FAIL_LIMIT = 5000,
    localparam int CNT_W     = $clog2(FAIL_LIMIT + 1),
    localparam int DEC_W     = (WARN_EVERY > 1) ? $clog2(WARN_EVERY) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic fail_ev,
    input  logic pass_ev,
    output logic warn_o,
    output logic livelock_o
);

    logic [CNT_W-1:0] run_q;
    logic [DEC_W-1:0] phase_q;
    logic             at_limit;
    logic             phase_wrap;

    assign at_limit   = (run_q == CNT_W'(FAIL_LIMIT));
    assign phase_wrap = (phase_q == DEC_W'(WARN_EVERY - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q      <= '0;
            phase_q    <= '0;
            warn_o     <= 1'b0;
            livelock_o <= 1'b0;
        end else if (fail_ev && !at_limit) begin
            run_q   <= run_q + 1'b1;
            phase_q <= phase_wrap ? '0 : phase_q + 1'b1;
            warn_o  <= phase_wrap;
            if (run_q == CNT_W'(FAIL_LIMIT - 1)) begin
                livelock_o <= 1'b1;
            end
        end else begin
            warn_o <= 1'b0;
            if (pass_ev) begin
                run_q   <= '0;
                phase_q <= '0;
            end
        end
    end

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int NTHREADS   = 4,
    parameter int ADDR_W     = 32,
    parameter int GRAN_BITS  = 4,
    parameter int WARN_EVERY = 10,
    parameter int FAIL_LIMIT = 5000,
    localparam int TID_W     = (NTHREADS > 1) ? $clog2(NTHREADS) : 1,
    localparam int TAG_W     = ADDR_W - GRAN_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_op,
    input  logic [TID_W-1:0]  req_tid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_uncached,
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_addr,
    output logic              rsp_valid,
    output logic [TID_W-1:0]  rsp_tid,
    output logic [1:0]        rsp_code,
    output logic [1:0]        rsp_cause,
    output logic              rsp_fwd,
    output logic              warn_pulse,
    output logic              livelock
);

    llsc_op_e                         op;
    logic                             take;
    logic                             take_ll;
    logic                             take_sc;
    logic [TAG_W-1:0]                 req_tag;
    logic [NTHREADS-1:0]              live;
    logic [NTHREADS-1:0][TAG_W-1:0]   tags;
    sc_verdict_t                      verdict;

    assign op        = llsc_op_e'(req_op);
    assign req_ready = !rst;
    assign take      = req_valid && req_ready;
    assign take_ll   = take && (op == OP_LOAD_LINK);
    assign take_sc   = take && (op == OP_STORE_COND);
    assign req_tag   = req_addr[ADDR_W-1:GRAN_BITS];

    llsc_resv_bank #(
        .NTHREADS (NTHREADS),
        .TAG_W    (TAG_W)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .set_en    (take_ll),
        .set_tid   (req_tid),
        .set_tag   (req_tag),
        .drop_en   (take_sc && !req_uncached),
        .drop_tid  (req_tid),
        .snoop_en  (inv_valid),
        .snoop_tag (inv_addr[ADDR_W-1:GRAN_BITS]),
        .live_o    (live),
        .tag_o     (tags)
    );

    llsc_sc_judge #(
        .TAG_W (TAG_W)
    ) u_judge (
        .uncached (req_uncached),
        .live     (live[req_tid]),
        .held_tag (tags[req_tid]),
        .req_tag  (req_tag),
        .verdict  (verdict)
    );

    llsc_fail_tracker #(
        .WARN_EVERY (WARN_EVERY),
        .FAIL_LIMIT (FAIL_LIMIT)
    ) u_track (
        .clk        (clk),
        .rst        (rst),
        .fail_ev    (take_sc && verdict.failed),
        .pass_ev    (take_sc && verdict.passed),
        .warn_o     (warn_pulse),
        .livelock_o (livelock)
    );

    always_ff @(posedge clk) begin
        if (rst || !take_sc) begin
            rsp_valid <= 1'b0;
            rsp_tid   <= '0;
            rsp_code  <= 2'd0;
            rsp_cause <= 2'd0;
            rsp_fwd   <= 1'b0;
        end else begin
            rsp_valid <= 1'b1;
            rsp_tid   <= req_tid;
            rsp_code  <= verdict.code;
            rsp_cause <= verdict.why;
            rsp_fwd   <= verdict.fwd;
        end
    end

endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
    parameter int TID_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_op,
    input logic             req_uncached,
    input logic             rsp_valid,
    input logic [1:0]       rsp_code,
    input logic [1:0]       rsp_cause,
    input logic             rsp_fwd,
    input logic             warn_pulse,
    input logic             livelock
);

    AST_RSP_FOLLOWS_SC: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && req_ready && req_op)); // R1

    AST_SC_MAKES_RSP: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_op) |=> rsp_valid); // R1

    AST_FAIL_HOLDS_STORE: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code == 2'd0) |-> (!rsp_fwd && rsp_cause != 2'd0)); // R3

    AST_BYPASS_FORWARDS: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code == 2'd2) |-> (rsp_fwd && $past(req_uncached))); // R6

    AST_WARN_ON_FAIL: assert property (@(posedge clk) disable iff (rst)
        warn_pulse |-> (rsp_valid && rsp_code == 2'd0)); // R9

    AST_LIVELOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(livelock) |-> livelock); // R11

    AST_LIVELOCK_RISE_ON_FAIL: assert property (@(posedge clk) disable iff (rst)
        $rose(livelock) |-> (rsp_valid && rsp_code == 2'd0)); // R11

endmodule

bind llsc_monitor llsc_monitor_chk #(.TID_W(TID_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_op       (req_op),
    .req_uncached (req_uncached),
    .rsp_valid    (rsp_valid),
    .rsp_code     (rsp_code),
    .rsp_cause    (rsp_cause),
    .rsp_fwd      (rsp_fwd),
    .warn_pulse   (warn_pulse),
    .livelock     (livelock)
);

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NT         = 4;
    localparam int AW         = 32;
    localparam int LIMIT      = 5000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_op = 1'b0;
    logic [1:0]    req_tid = '0;
    logic [AW-1:0] req_addr = '0;
    logic          req_uncached = 1'b0;
    logic          inv_valid = 1'b0;
    logic [AW-1:0] inv_addr = '0;
    logic          rsp_valid;
    logic [1:0]    rsp_tid;
    logic [1:0]    rsp_code;
    logic [1:0]    rsp_cause;
    logic          rsp_fwd;
    logic          warn_pulse;
    logic          livelock;

    always #(CLK_PERIOD / 2) clk = ~clk;

    llsc_monitor u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_tid(req_tid), .req_addr(req_addr),
        .req_uncached(req_uncached), .inv_valid(inv_valid), .inv_addr(inv_addr),
        .rsp_valid(rsp_valid), .rsp_tid(rsp_tid), .rsp_code(rsp_code),
        .rsp_cause(rsp_cause), .rsp_fwd(rsp_fwd), .warn_pulse(warn_pulse),
        .livelock(livelock)
    );

    // behavioural reference state
    bit            m_live [NT];
    int unsigned   m_gran [NT];
    int            m_fails = 0;
    bit            m_lock = 0;
    bit            e_valid = 0, e_fwd = 0, e_warn = 0;
    int            e_code = 0, e_cause = 0, e_tid = 0;
    string         e_tag = "R1";
    string         phase = "R12";

    int checks = 0;
    int errors = 0;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s (%s) t=%0t actual=%0d expected=%0d", req, phase, $time, act, exp);
        end
    endtask

    task automatic compare();
        chk("R1", int'(req_ready), rst ? 0 : 1);
        chk("R1", int'(rsp_valid), int'(e_valid));
        chk(e_tag, int'(rsp_code), e_code);
        chk(e_tag, int'(rsp_cause), e_cause);
        chk(e_tag, int'(rsp_fwd), int'(e_fwd));
        chk("R1", int'(rsp_tid), e_tid);
        chk("R9", int'(warn_pulse), int'(e_warn));
        chk("R11", int'(livelock), int'(m_lock));
    endtask

    // reference step: inputs already driven for the coming edge
    task automatic model_step();
        bit sc_drop = 0;
        e_valid = 0; e_code = 0; e_cause = 0; e_fwd = 0; e_tid = 0; e_warn = 0; e_tag = "R1";
        if (req_valid && req_op) begin
            e_valid = 1;
            e_tid = int'(req_tid);
            if (req_uncached) begin
                e_code = 2; e_fwd = 1; e_tag = "R6";
            end else begin
                sc_drop = 1;
                if (!m_live[req_tid]) begin
                    e_cause = 1; e_tag = "R3";
                end else if (m_gran[req_tid] != (req_addr >> 4)) begin
                    e_cause = 2; e_tag = "R4";
                end
                if (e_cause != 0) begin
                    if (m_fails < LIMIT) begin
                        m_fails++;
                        if (m_fails % 10 == 0) e_warn = 1;
                        if (m_fails == LIMIT) m_lock = 1;
                    end
                end else begin
                    e_code = 1; e_fwd = 1; e_tag = "R5";
                    m_fails = 0;
                end
            end
        end
        if (inv_valid) begin
            for (int t = 0; t < NT; t++) begin
                if (m_live[t] && m_gran[t] == (inv_addr >> 4)) m_live[t] = 0;
            end
        end
        if (req_valid && !req_op) begin
            m_live[req_tid] = 1;
            m_gran[req_tid] = req_addr >> 4;
        end
        if (sc_drop) m_live[req_tid] = 0;
    endtask

    task automatic step(bit v, bit op, int tid, int unsigned a, bit unc, bit iv, int unsigned ia);
        @(negedge clk);
        compare();
        req_valid = v; req_op = op; req_tid = 2'(tid); req_addr = a;
        req_uncached = unc; inv_valid = iv; inv_addr = ia;
        model_step();
    endtask

    task automatic ll(int tid, int unsigned a);
        step(1, 0, tid, a, 0, 0, 0);
    endtask

    task automatic sc(int tid, int unsigned a, bit unc = 0);
        step(1, 1, tid, a, unc, 0, 0);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        for (int t = 0; t < NT; t++) begin
            m_live[t] = 0;
            m_gran[t] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        compare();
        rst = 1'b0;
        model_step();

        phase = "R3";
        sc(0, 32'h100);
        sc(0, 32'h2000);
        idle();

        phase = "R2";
        ll(1, 32'h1234);
        sc(1, 32'h123C);
        sc(1, 32'h1230);
        idle();

        phase = "R4";
        ll(2, 32'h2000);
        sc(2, 32'h2010);
        sc(2, 32'h2000);

        phase = "R6";
        ll(3, 32'h3000);
        sc(3, 32'h9999, 1);
        sc(3, 32'h3004);

        phase = "R7";
        ll(0, 32'h40);
        ll(1, 32'h80);
        sc(1, 32'h80);
        sc(0, 32'h4F);

        phase = "R8";
        ll(0, 32'h500);
        ll(1, 32'h508);
        ll(2, 32'h600);
        step(0, 0, 0, 0, 0, 1, 32'h50C);
        sc(0, 32'h500);
        sc(1, 32'h500);
        sc(2, 32'h600);
        step(1, 0, 3, 32'h700, 0, 1, 32'h704);
        sc(3, 32'h700);
        ll(2, 32'h800);
        step(1, 1, 2, 32'h800, 0, 1, 32'h800);
        idle();

        phase = "R9";
        for (int i = 0; i < 25; i++) sc(0, 32'h10);
        phase = "R10";
        ll(0, 32'h10);
        sc(0, 32'h10);
        for (int i = 0; i < 5; i++) sc(1, 32'h20);
        sc(2, 32'h30, 1);
        for (int i = 0; i < 6; i++) sc(1, 32'h20);
        idle();

        phase = "RND";
        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, $urandom_range(0, 3),
                 ($urandom_range(0, 3) << 4) | $urandom_range(0, 15),
                 $urandom_range(0, 9) == 0, $urandom_range(0, 7) == 0,
                 ($urandom_range(0, 3) << 4) | $urandom_range(0, 15));
        end

        phase = "R11";
        ll(3, 32'h10);
        sc(3, 32'h10);
        for (int i = 0; i < LIMIT + 20; i++) sc(2, 32'h70);
        idle();
        idle();
        @(negedge clk);
        compare();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule